// File: doc/BRIEF.md
# RTC Alarm Match Flag

This block watches the calendar counters of a real-time clock and compares them with six alarm fields: second, minute, hour, day of week, day of month and month. Each field holds a BCD compare value and its own enable bit. When every enabled field equals its counter, a sticky alarm flag is raised. The flag stays up until software clears it, and it can drive an interrupt request if the interrupt enable is set.

Software reaches the six alarm fields and one control register through a small single-cycle register port. A write takes effect at the clock edge where `bus_wr` is high. Reads are combinational from the stored state. The counters, their carries, the prescaler and any periodic or adjust functions live outside this block.

Top module: `rtc_alarm_match`

## Requirements
- R1: Addresses 0 to 5 hold the alarm fields in this order: second, minute, hour, day of week, day of month, month. Each field is 8 bits: bit 7 is the enable and bits 6:0 are the compare value. A field reads back exactly the value last written to it.
- R2: A field whose enable bit is 0 takes no part in the comparison, so its compare value has no effect on the flag.
- R3: The alarm flag is bit 0 of the control register at address 6. It becomes 1 at the first clock edge where every enabled field's bits 6:0 equal the matching counter. Both the read value and `alarm_irq` show it after that edge.
- R4: When no field is enabled, the flag never sets, whatever the counters hold.
- R5: Once set, the flag stays 1 after the counters stop matching.
- R6: A write to address 6 with bit 0 at 0 clears the flag. A write with bit 0 at 1 leaves the flag unchanged.
- R7: If a clearing write and a match fall on the same edge, the flag ends up 1.
- R8: Bit 3 of the control register is the alarm interrupt enable, and it reads back as written. All other control bits, including the reserved bits 6, 5, 2 and 1, ignore writes and read as 0. Address 7 reads as 0.
- R9: `alarm_irq` is 1 exactly when both the flag and the interrupt enable are 1.
- R10: After reset, all alarm fields, the flag and the interrupt enable are 0, and `alarm_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_sec | input | 7 | Current seconds counter (BCD) |
| cnt_min | input | 7 | Current minutes counter (BCD) |
| cnt_hour | input | 7 | Current hours counter (BCD) |
| cnt_wday | input | 7 | Current day-of-week counter |
| cnt_mday | input | 7 | Current day-of-month counter (BCD) |
| cnt_month | input | 7 | Current month counter (BCD) |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
A register write is visible on `bus_rdata` right after the edge that captures it. A counter change applied before an edge moves the flag and `alarm_irq` at that same edge, so each result is due one edge after its stimulus. The bench drives every input on a falling edge and lets exactly one rising edge pass. It then sets the read address on the next falling edge and lets the values settle for 1 ns before it queues the expected item. The scoreboard monitor compares the item at that point, in the middle of the low phase, well away from any rising edge.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int NUM_FIELDS = 6;
    localparam int VAL_W      = 7;
    localparam int REG_W      = VAL_W + 1;
    localparam int ADDR_W     = 3;
    localparam int CTRL_ADDR  = NUM_FIELDS;
    localparam int FLAG_BIT   = 0;
    localparam int IE_BIT     = 3;

    typedef struct packed {
        logic             en;
        logic [VAL_W-1:0] val;
    } alarm_field_t;

    typedef struct packed {
        logic flag;
        logic ie;
    } ctrl_t;
endpackage

// File: rtl/rtc_alarm_field_cmp.sv
module rtc_alarm_field_cmp
    import rtc_alarm_pkg::*;
(
    input  alarm_field_t     fld_i,
    input  logic [VAL_W-1:0] cnt_i,
    output logic             armed_o,
    output logic             ok_o
);
    always_comb begin
        armed_o = fld_i.en;
        ok_o    = !fld_i.en || (fld_i.val == cnt_i);
    end
endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [REG_W-1:0]              wdata_i,
    output alarm_field_t [NUM_FIELDS-1:0] fields_o
);
    typedef struct packed {
        alarm_field_t [NUM_FIELDS-1:0] fld;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (addr_i == ADDR_W'(i)) begin
                    st_d.fld[i] = alarm_field_t'(wdata_i);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fields_o = st_q.fld;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_store_chk
        // R1
        alm_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && addr_i == ADDR_W'(g)) |=> (fields_o[g] == $past(wdata_i)));
    end
endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
    import rtc_alarm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_i,
    input  logic  flag_wdata_i,
    input  logic  ie_wdata_i,
    input  logic  match_i,
    output ctrl_t ctrl_o,
    output logic  irq_o
);
    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.ie = ie_wdata_i;
            if (!flag_wdata_i) begin
                st_d.flag = 1'b0;
            end
        end
        if (match_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q;
    assign irq_o  = st_q.flag && st_q.ie;

    // R3 / R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> ctrl_o.flag);
    // R6
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !flag_wdata_i && !match_i) |=> !ctrl_o.flag);
    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o.flag && !(wr_i && !flag_wdata_i)) |=> ctrl_o.flag);
    // R3
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_o.flag) |-> $past(match_i));
    // R8
    ie_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (ctrl_o.ie == $past(ie_wdata_i)));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VAL_W-1:0]  cnt_sec,
    input  logic [VAL_W-1:0]  cnt_min,
    input  logic [VAL_W-1:0]  cnt_hour,
    input  logic [VAL_W-1:0]  cnt_wday,
    input  logic [VAL_W-1:0]  cnt_mday,
    input  logic [VAL_W-1:0]  cnt_month,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              alarm_irq
);
    localparam logic [REG_W-1:0] CTRL_LIVE = REG_W'((1 << FLAG_BIT) | (1 << IE_BIT));

    alarm_field_t [NUM_FIELDS-1:0] fields;
    logic [NUM_FIELDS-1:0][VAL_W-1:0] cnt_arr;
    logic [NUM_FIELDS-1:0] armed, ok;
    logic match, ctrl_wr;
    ctrl_t ctrl;

    assign cnt_arr = {cnt_month, cnt_mday, cnt_wday, cnt_hour, cnt_min, cnt_sec};
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

    rtc_alarm_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .fields_o (fields)
    );

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        rtc_alarm_field_cmp u_cmp (
            .fld_i   (fields[g]),
            .cnt_i   (cnt_arr[g]),
            .armed_o (armed[g]),
            .ok_o    (ok[g])
        );
    end

    assign match = (|armed) && (&ok);

    rtc_alarm_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (ctrl_wr),
        .flag_wdata_i (bus_wdata[FLAG_BIT]),
        .ie_wdata_i   (bus_wdata[IE_BIT]),
        .match_i      (match),
        .ctrl_o       (ctrl),
        .irq_o        (alarm_irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (bus_addr == ADDR_W'(i)) begin
                bus_rdata = fields[i];
            end
        end
        if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
            bus_rdata[FLAG_BIT] = ctrl.flag;
            bus_rdata[IE_BIT]   = ctrl.ie;
        end
    end

    // R4
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|armed) |-> !match);
    // R8
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(CTRL_ADDR)) |-> ((bus_rdata & ~CTRL_LIVE) == '0));
    // R9
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (bus_addr != ADDR_W'(CTRL_ADDR) || bus_rdata[FLAG_BIT]));
endmodule

// File: tb/rtc_alarm_match_test.sv
`timescale 1ns/1ps
module rtc_alarm_match_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] cnt_sec = '0, cnt_min = '0, cnt_hour = '0;
    logic [6:0] cnt_wday = '0, cnt_mday = '0, cnt_month = '0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       alarm_irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        logic [2:0] addr;
        logic [7:0] rd;
        logic       irq;
        string      tag;
    } item_t;

    item_t sb[$];
    event chk_ev;

    always #2 clk = ~clk;

    rtc_alarm_match uut (
        .clk(clk), .rst_n(rst_n),
        .cnt_sec(cnt_sec), .cnt_min(cnt_min), .cnt_hour(cnt_hour),
        .cnt_wday(cnt_wday), .cnt_mday(cnt_mday), .cnt_month(cnt_month),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
    );

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                total++;
                if (bus_rdata !== it.rd || alarm_irq !== it.irq) begin
                    bad++;
                    $display("FAIL %s addr=%0d rdata=%h exp=%h irq=%b exp=%b",
                             it.tag, it.addr, bus_rdata, it.rd, alarm_irq, it.irq);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [7:0] rd,
                             input logic irq, input string tag);
        item_t it;
        bus_addr = a;
        #1;
        it.addr = a; it.rd = rd; it.irq = irq; it.tag = tag;
        sb.push_back(it);
        -> chk_ev;
        #0.1;
    endtask

    task automatic set_cnt(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                           input logic [6:0] w, input logic [6:0] d, input logic [6:0] mo);
        @(negedge clk);
        cnt_sec = s; cnt_min = m; cnt_hour = h;
        cnt_wday = w; cnt_mday = d; cnt_month = mo;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R10 reset state
        for (int a = 0; a < 8; a++) expect_rd(3'(a), 8'h00, 1'b0, "R10");

        set_cnt(7'h15, 7'h42, 7'h09, 7'h03, 7'h21, 7'h07);
        // R4: equal values but nothing enabled
        wr(0, 8'h15); wr(1, 8'h42); wr(2, 8'h09);
        wr(3, 8'h03); wr(4, 8'h21); wr(5, 8'h07);
        repeat (3) tick();
        expect_rd(6, 8'h00, 1'b0, "R4");
        // R1 readback
        expect_rd(4, 8'h21, 1'b0, "R1");
        // R8 control write of all ones keeps only the enable bit
        wr(6, 8'hFF);
        expect_rd(6, 8'h08, 1'b0, "R8");
        expect_rd(7, 8'h00, 1'b0, "R8");
        // enable second field with a value not yet reached
        wr(0, 8'h96);
        expect_rd(0, 8'h96, 1'b0, "R1");
        tick();
        expect_rd(6, 8'h08, 1'b0, "R3");
        // R3 / R9: counter reaches the value
        set_cnt(7'h16, 7'h42, 7'h09, 7'h03, 7'h21, 7'h07);
        tick();
        expect_rd(6, 8'h09, 1'b1, "R3");
        // R5 sticky
        set_cnt(7'h17, 7'h42, 7'h09, 7'h03, 7'h21, 7'h07);
        repeat (2) tick();
        expect_rd(6, 8'h09, 1'b1, "R5");
        // R6 write one ignored, write zero clears
        wr(6, 8'h09);
        expect_rd(6, 8'h09, 1'b1, "R6");
        wr(6, 8'h08);
        expect_rd(6, 8'h08, 1'b0, "R6");
        // R2: hour disabled with wrong value, minute enabled
        wr(2, 8'h11);
        wr(1, 8'hC2);
        tick();
        expect_rd(6, 8'h08, 1'b0, "R2");
        set_cnt(7'h16, 7'h42, 7'h09, 7'h03, 7'h21, 7'h07);
        tick();
        expect_rd(6, 8'h09, 1'b1, "R2");
        // R7 clear during match: set wins
        wr(6, 8'h08);
        expect_rd(6, 8'h09, 1'b1, "R7");
        // R9 enable off with flag held by match
        wr(6, 8'h00);
        expect_rd(6, 8'h01, 1'b0, "R9");
        set_cnt(7'h16, 7'h43, 7'h09, 7'h03, 7'h21, 7'h07);
        wr(6, 8'h00);
        expect_rd(6, 8'h00, 1'b0, "R6");
        // R3 all six enabled, one field differs
        wr(0, 8'h96); wr(1, 8'hC2); wr(2, 8'h89);
        wr(3, 8'h83); wr(4, 8'hA1); wr(5, 8'h87);
        wr(6, 8'h08);
        repeat (2) tick();
        expect_rd(6, 8'h08, 1'b0, "R3");
        set_cnt(7'h16, 7'h42, 7'h09, 7'h03, 7'h21, 7'h08);
        repeat (2) tick();
        expect_rd(6, 8'h08, 1'b0, "R3");
        set_cnt(7'h16, 7'h42, 7'h09, 7'h03, 7'h21, 7'h07);
        tick();
        expect_rd(6, 8'h09, 1'b1, "R3");
        expect_rd(5, 8'h87, 1'b1, "R1");

        finished = 1;
        tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule